// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the software-facing side of a serial port. A word-addressed read/write bus reaches a set of 16-bit control and status registers. Bytes that arrive from the line side land in a one-character holding buffer. Bytes written by software leave as a one-cycle strobe. A single registered interrupt line tells the processor that a character is waiting, or that the transmitter is ready. Bit-level shifting, baud generation, FIFOs, DMA and modem pins are handled elsewhere or not at all.

The receive side is a two-state machine. In `RX_EMPTY`, `rx_ready` is high. The transition `CAPTURE` (a valid byte or break offered by the line side) moves it to `RX_FULL` and stores the word. In `RX_FULL`, `rx_ready` is low and further offers are refused. The transition `DRAIN` (a bus read of the receive data word) returns it to `RX_EMPTY`. A third transition, `SOFT_RESET` (a control-2 write with bit 0 low), forces `RX_EMPTY` from either state. Bus reads take effect at the clock edge that ends the read cycle. `bus_rdata` shows the register contents during that cycle.

Top module: `uart_regfront`

## Requirements
- R1: After reset, the registers read back as follows. Receive data (word 0x00) reads 0x4000. Control 1 (0x20) reads 0x0000, control 2 (0x21) 0x0001 and control 3 (0x22) 0x0700. Status 1 (0x25) reads 0x6040 and status 2 (0x26) 0x4028. Test/status (0x2D) reads 0x0060, baud modulator (0x2A) 0x0000 and baud count (0x2B) 0x0004. `rx_ready` is 1 and `irq` is 0.
- R2: A byte offered with `rx_valid` high while `rx_ready` is high is stored at that clock edge. After that edge, status 1 bit 9 and status 2 bit 0 read 1, test bit 5 reads 0 and `rx_ready` is 0. While the buffer is full, offered bytes are refused and the stored word is unchanged.
- R3: Reading word 0x00 while the buffer is full returns the stored word with bit 15 set. The same read empties the buffer: status 1 bit 9 and status 2 bit 0 clear, test bit 5 sets and `rx_ready` returns to 1. Reading word 0x00 while the buffer is empty returns the stored word with bit 15 clear.
- R4: An offer with `rx_brk` high stores the word 0x0800 in place of the data byte.
- R5: A write to word 0x10 produces `tx_strobe` for one cycle, starting the cycle after the write, with `tx_byte` equal to bits 7:0 of the write data. This happens only when control 2 bit 2 is 1; otherwise the write produces no strobe.
- R6: A write to control 2 with data bit 0 equal to 0 returns every register and the receive buffer to the R1 values, except control 2. Control 2 then reads the written low 16 bits with bit 0 forced to 1. The FIFO-control and millisecond registers return to 0.
- R7: Writing 1 to a status 1 bit clears it only for bits 15, 12, 11, 10, 8, 7, 5 and 4. Writing 1 to a status 2 bit clears it only for bits 15, 13, 12, 11, 10, 8, 7, 6, 4, 2 and 1. All other status bits are unaffected by the write.
- R8: `irq` is 1 in a cycle exactly when, one cycle earlier, one of two terms held. The receive term is control 1 bit 9 together with a full buffer. The transmit term is control 1 bit 13 together with control 1 bit 6 and status 1 bit 13.
- R9: Control 1, control 3, FIFO control (0x24), baud modulator (0x2A) and millisecond (0x2C) store the low 16 bits of a write and read them back. A write to 0x29 is stored in the baud count register read at 0x2B. Reads of 0x23 and 0x29 return 0.
- R10: Writes to unmapped words, to control 4 (0x23) and to the test/status word (0x2D) change nothing. Reads of unmapped words return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle; side effects at the closing edge |
| bus_addr | input | 8 | Word index of the register |
| bus_wdata | input | 32 | Write data; only bits 15:0 are kept |
| bus_rdata | output | 32 | Read data for the addressed word, bits 31:16 zero |
| rx_valid | input | 1 | Line side offers a received item |
| rx_data | input | 8 | Received byte |
| rx_brk | input | 1 | Offered item is a break condition |
| rx_ready | output | 1 | Holding buffer is empty and will accept an offer |
| tx_strobe | output | 1 | One-cycle pulse: a byte is sent |
| tx_byte | output | 8 | Byte being sent while `tx_strobe` is high |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest situation to reach is a soft reset that lands while the buffer is full and the interrupt is active. Reaching it means first filling the buffer through the handshake and enabling both interrupt terms. Only then does the stimulus issue the control-2 write with bit 0 clear, after which every register, the buffer state and the interrupt are read back through the bus and the pins. The refused-offer case is reached by offering a second byte before draining the first, then checking that the drained word is the first byte.

// File: rtl/uart_regfront_pkg.sv
package uart_regfront_pkg;
    localparam int REG_W  = 16;
    localparam int ADDR_W = 8;
    localparam int BYTE_W = 8;

    // Word indices
    localparam logic [ADDR_W-1:0] A_RXD   = 8'h00;
    localparam logic [ADDR_W-1:0] A_TXD   = 8'h10;
    localparam logic [ADDR_W-1:0] A_CTL1  = 8'h20;
    localparam logic [ADDR_W-1:0] A_CTL2  = 8'h21;
    localparam logic [ADDR_W-1:0] A_CTL3  = 8'h22;
    localparam logic [ADDR_W-1:0] A_CTL4  = 8'h23;
    localparam logic [ADDR_W-1:0] A_FIFO  = 8'h24;
    localparam logic [ADDR_W-1:0] A_STA1  = 8'h25;
    localparam logic [ADDR_W-1:0] A_STA2  = 8'h26;
    localparam logic [ADDR_W-1:0] A_BINC  = 8'h29;
    localparam logic [ADDR_W-1:0] A_BMOD  = 8'h2A;
    localparam logic [ADDR_W-1:0] A_BCNT  = 8'h2B;
    localparam logic [ADDR_W-1:0] A_MSEC  = 8'h2C;
    localparam logic [ADDR_W-1:0] A_TEST  = 8'h2D;

    // Bit positions
    localparam int S1_RXRDY   = 9;
    localparam int S1_TXRDY   = 13;
    localparam int S2_DATRDY  = 0;
    localparam int C1_TXE_EN  = 6;
    localparam int C1_RX_EN   = 9;
    localparam int C1_TX_EN   = 13;
    localparam int C2_RUN     = 0;
    localparam int C2_TXON    = 2;
    localparam int T_RXEMPTY  = 5;
    localparam int WORD_VALID = 15;

    // Reset values and masks
    localparam logic [REG_W-1:0] RST_STA1  = 16'h6040;
    localparam logic [REG_W-1:0] RST_STA2  = 16'h4028;
    localparam logic [REG_W-1:0] TEST_BASE = 16'h0040;
    localparam logic [REG_W-1:0] RST_CTL2  = 16'h0001;
    localparam logic [REG_W-1:0] RST_CTL3  = 16'h0700;
    localparam logic [REG_W-1:0] RST_BCNT  = 16'h0004;
    localparam logic [REG_W-1:0] RST_RXW   = 16'h4000;
    localparam logic [REG_W-1:0] BRK_WORD  = 16'h0800;
    localparam logic [REG_W-1:0] W1C_STA1  = 16'h9DB0;
    localparam logic [REG_W-1:0] W1C_STA2  = 16'hBDD6;

    typedef enum logic {
        RX_EMPTY = 1'b0,
        RX_FULL  = 1'b1
    } rx_state_e;
endpackage

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
    import uart_regfront_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst,
    input  logic              drain,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_brk,
    output logic              full,
    output logic [REG_W-1:0]  word
);
    rx_state_e         state_q, state_d;
    logic [REG_W-1:0]  word_q;
    logic              capture;

    assign capture = (state_q == RX_EMPTY) && rx_valid && !srst;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_EMPTY: if (rx_valid) state_d = RX_FULL;
            RX_FULL:  if (drain)    state_d = RX_EMPTY;
        endcase
        if (srst) state_d = RX_EMPTY;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_EMPTY;
            word_q  <= RST_RXW;
        end else begin
            state_q <= state_d;
            if (srst)
                word_q <= RST_RXW;
            else if (capture)
                word_q <= rx_brk ? BRK_WORD : {{(REG_W-BYTE_W){1'b0}}, rx_data};
        end
    end

    always_comb begin
        full = (state_q == RX_FULL);
        word = word_q;
    end

    AST_RX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !drain && !srst) |=> (full && $stable(word))); // R2
endmodule

// File: rtl/uart_ctrl_regs.sv
module uart_ctrl_regs
    import uart_regfront_pkg::*;
#(
    parameter int BUS_W = 32
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic              full,
    input  logic [REG_W-1:0]  rx_word,
    output logic              srst,
    output logic [BUS_W-1:0]  rdata,
    output logic [REG_W-1:0]  ctl1,
    output logic [REG_W-1:0]  ctl2,
    output logic [REG_W-1:0]  sta1_view
);
    localparam int HI_W = BUS_W - REG_W;

    logic [REG_W-1:0] wd;
    logic             unused_hi;
    logic [REG_W-1:0] ctl1_q, ctl2_q, ctl3_q, fifo_q, msec_q, bmod_q, bcnt_q;
    logic [REG_W-1:0] sta1_q, sta2_q;
    logic [REG_W-1:0] sta2_view, test_view, rv;

    assign wd        = wdata[REG_W-1:0];
    assign unused_hi = ^wdata[BUS_W-1:REG_W];
    assign srst      = wr && (addr == A_CTL2) && !wd[C2_RUN];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl1_q <= '0;       ctl2_q <= RST_CTL2; ctl3_q <= RST_CTL3;
            fifo_q <= '0;       msec_q <= '0;
            bmod_q <= '0;       bcnt_q <= RST_BCNT;
            sta1_q <= RST_STA1; sta2_q <= RST_STA2;
        end else if (srst) begin
            ctl1_q <= '0;       ctl2_q <= wd | RST_CTL2; ctl3_q <= RST_CTL3;
            fifo_q <= '0;       msec_q <= '0;
            bmod_q <= '0;       bcnt_q <= RST_BCNT;
            sta1_q <= RST_STA1; sta2_q <= RST_STA2;
        end else if (wr) begin
            case (addr)
                A_CTL1: ctl1_q <= wd;
                A_CTL2: ctl2_q <= wd;
                A_CTL3: ctl3_q <= wd;
                A_FIFO: fifo_q <= wd;
                A_MSEC: msec_q <= wd;
                A_BMOD: bmod_q <= wd;
                A_BINC: bcnt_q <= wd;
                A_STA1: sta1_q <= sta1_q & ~(wd & W1C_STA1);
                A_STA2: sta2_q <= sta2_q & ~(wd & W1C_STA2);
                default: ;
            endcase
        end
    end

    always_comb begin
        sta1_view = sta1_q | (REG_W'(full) << S1_RXRDY);
        sta2_view = sta2_q | (REG_W'(full) << S2_DATRDY);
        test_view = TEST_BASE | (REG_W'(!full) << T_RXEMPTY);
        rv = '0;
        case (addr)
            A_RXD:  rv = rx_word | (REG_W'(full) << WORD_VALID);
            A_CTL1: rv = ctl1_q;
            A_CTL2: rv = ctl2_q;
            A_CTL3: rv = ctl3_q;
            A_FIFO: rv = fifo_q;
            A_STA1: rv = sta1_view;
            A_STA2: rv = sta2_view;
            A_BMOD: rv = bmod_q;
            A_BCNT: rv = bcnt_q;
            A_MSEC: rv = msec_q;
            A_TEST: rv = test_view;
            default: rv = '0;
        endcase
        rdata = {{HI_W{1'b0}}, rv};
        ctl1  = ctl1_q;
        ctl2  = ctl2_q;
    end

    AST_RUN_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ctl2_q[C2_RUN]); // R6
    AST_STA1_RO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        !srst |=> ((sta1_q & ~W1C_STA1) == $past(sta1_q & ~W1C_STA1))); // R7
    AST_STA2_RO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        !srst |=> ((sta2_q & ~W1C_STA2) == $past(sta2_q & ~W1C_STA2))); // R7
endmodule

// File: rtl/uart_tx_port.sv
module uart_tx_port
    import uart_regfront_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              send,
    input  logic              tx_on,
    input  logic [BYTE_W-1:0] din,
    output logic              strobe,
    output logic [BYTE_W-1:0] dout
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe <= 1'b0;
            dout   <= '0;
        end else begin
            strobe <= send && tx_on;
            if (send && tx_on) dout <= din;
        end
    end
endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen
    import uart_regfront_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] ctl1,
    input  logic [REG_W-1:0] sta1,
    output logic             irq
);
    logic rx_term, tx_term;

    always_comb begin
        rx_term = sta1[S1_RXRDY] && ctl1[C1_RX_EN];
        tx_term = sta1[S1_TXRDY] && ctl1[C1_TX_EN] && ctl1[C1_TXE_EN];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= rx_term || tx_term;
    end
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
    import uart_regfront_pkg::*;
#(
    parameter int BUS_W = 32
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_brk,
    output logic              rx_ready,
    output logic              tx_strobe,
    output logic [7:0]        tx_byte,
    output logic              irq
);
    logic             srst, full, drain, send;
    logic [REG_W-1:0] rx_word, ctl1, ctl2, sta1_view;

    assign drain    = bus_rd && (bus_addr == A_RXD);
    assign send     = bus_wr && (bus_addr == A_TXD);
    assign rx_ready = !full;

    uart_rx_hold i_rx (
        .clk(clk), .rst_n(rst_n), .srst(srst), .drain(drain),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_brk(rx_brk),
        .full(full), .word(rx_word)
    );

    uart_ctrl_regs #(.BUS_W(BUS_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .full(full), .rx_word(rx_word), .srst(srst),
        .rdata(bus_rdata), .ctl1(ctl1), .ctl2(ctl2), .sta1_view(sta1_view)
    );

    uart_tx_port i_tx (
        .clk(clk), .rst_n(rst_n), .send(send), .tx_on(ctl2[C2_TXON]),
        .din(bus_wdata[7:0]), .strobe(tx_strobe), .dout(tx_byte)
    );

    uart_irq_gen i_irq (
        .clk(clk), .rst_n(rst_n), .ctl1(ctl1), .sta1(sta1_view), .irq(irq)
    );

    AST_RX_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready && !srst) |=> !rx_ready); // R2
    AST_RX_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
        (drain && !rx_ready) |=> rx_ready); // R3
    AST_TX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe |-> $past(send && ctl2[C2_TXON])); // R5
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past((ctl1[C1_RX_EN] && !rx_ready) ||
                      (ctl1[C1_TX_EN] && ctl1[C1_TXE_EN] && sta1_view[S1_TXRDY]))); // R8
endmodule

// File: tb/test_uart_regfront.sv
module test_uart_regfront;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_valid = 1'b0, rx_brk = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready, tx_strobe, irq;
    logic [7:0]  tx_byte;

    int compared = 0;
    int mismatched = 0;

    typedef struct { logic [31:0] val; string req; } exp_t;
    exp_t rd_q[$];
    exp_t tx_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_regfront i_uart_regfront (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_brk(rx_brk),
        .rx_ready(rx_ready), .tx_strobe(tx_strobe), .tx_byte(tx_byte), .irq(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Monitor: samples a quarter period after each falling edge
    always begin
        exp_t e;
        @(negedge clk);
        #(CLK_PERIOD/4);
        if (rst_n && bus_rd) begin
            if (rd_q.size() == 0) check("read without expectation", 32'h1, 32'h0);
            else begin e = rd_q.pop_front(); check(e.req, bus_rdata, e.val); end
        end
        if (rst_n && tx_strobe) begin
            if (tx_q.size() == 0) check("R5 unexpected tx_strobe", {24'h0, tx_byte}, 32'hFFFF_FFFF);
            else begin e = tx_q.pop_front(); check(e.req, {24'h0, tx_byte}, e.val); end
        end
    end

    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [7:0] a, logic [31:0] exp, string req);
        exp_t e;
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        e.val = exp; e.req = req; rd_q.push_back(e);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic send_byte(logic [31:0] d, string req);
        exp_t e;
        e.val = {24'h0, d[7:0]}; e.req = req; tx_q.push_back(e);
        bus_write(8'h10, d);
    endtask

    task automatic rx_push(logic [7:0] d, logic brk);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = d; rx_brk = brk;
        @(negedge clk);
        rx_valid = 1'b0; rx_brk = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
        #(CLK_PERIOD/4);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #(CLK_PERIOD/4);
        // R1 reset state
        check("R1 rx_ready", {31'h0, rx_ready}, 32'h1);
        check("R1 irq", {31'h0, irq}, 32'h0);
        bus_read(8'h00, 32'h4000, "R1 rx word");
        bus_read(8'h20, 32'h0000, "R1 ctl1");
        bus_read(8'h21, 32'h0001, "R1 ctl2");
        bus_read(8'h22, 32'h0700, "R1 ctl3");
        bus_read(8'h25, 32'h6040, "R1 status1");
        bus_read(8'h26, 32'h4028, "R1 status2");
        bus_read(8'h2D, 32'h0060, "R1 test");
        bus_read(8'h2A, 32'h0000, "R1 baud mod");
        bus_read(8'h2B, 32'h0004, "R1 baud count");

        // R5 transmit gating
        bus_write(8'h10, 32'h1234);
        settle();
        bus_write(8'h21, 32'h0005);
        send_byte(32'hABCD, "R5 tx byte");
        send_byte(32'h0011, "R5 tx byte second");
        settle();
        check("R5 all strobes seen", rd_q.size() + tx_q.size(), 0);

        // R2 / R3 receive buffer
        rx_push(8'h5A, 1'b0);
        #(CLK_PERIOD/4);
        check("R2 rx_ready low when full", {31'h0, rx_ready}, 32'h0);
        bus_read(8'h25, 32'h6240, "R2 status1 full");
        bus_read(8'h26, 32'h4029, "R2 status2 full");
        bus_read(8'h2D, 32'h0040, "R2 test full");
        rx_push(8'h77, 1'b0);
        bus_read(8'h00, 32'h805A, "R2 R3 first byte kept, valid bit");
        #(CLK_PERIOD/4);
        check("R3 rx_ready after drain", {31'h0, rx_ready}, 32'h1);
        bus_read(8'h25, 32'h6040, "R3 status1 drained");
        bus_read(8'h26, 32'h4028, "R3 status2 drained");
        bus_read(8'h2D, 32'h0060, "R3 test drained");
        bus_read(8'h00, 32'h005A, "R3 read when empty");

        // R4 break
        rx_push(8'hC3, 1'b1);
        bus_read(8'h00, 32'h8800, "R4 break word");

        // R8 interrupt
        bus_write(8'h20, 32'h0200);
        settle();
        check("R8 rx enable, empty", {31'h0, irq}, 32'h0);
        rx_push(8'h31, 1'b0);
        settle();
        check("R8 rx term", {31'h0, irq}, 32'h1);
        bus_read(8'h00, 32'h8031, "R8 drain");
        settle();
        check("R8 drain clears", {31'h0, irq}, 32'h0);
        bus_write(8'h20, 32'h2000);
        settle();
        check("R8 tx term needs empty enable", {31'h0, irq}, 32'h0);
        bus_write(8'h20, 32'h2040);
        settle();
        check("R8 tx term", {31'h0, irq}, 32'h1);

        // R7 write-one-to-clear masks
        bus_write(8'h25, 32'hFFFF);
        bus_read(8'h25, 32'h6040, "R7 status1 ro bits");
        bus_write(8'h26, 32'hFFFF);
        bus_read(8'h26, 32'h4028, "R7 status2 ro bits");

        // R9 storage registers
        bus_write(8'h22, 32'hDEAD_BEEF);
        bus_read(8'h22, 32'h0000_BEEF, "R9 ctl3 low half");
        bus_write(8'h24, 32'h0001_0801);
        bus_read(8'h24, 32'h0801, "R9 fifo ctl");
        bus_write(8'h2C, 32'h0000_03E8);
        bus_read(8'h2C, 32'h03E8, "R9 msec");
        bus_write(8'h2A, 32'hFFFF_1357);
        bus_read(8'h2A, 32'h1357, "R9 baud mod");
        bus_write(8'h29, 32'h0001_2345);
        bus_read(8'h2B, 32'h2345, "R9 increment lands in count");
        bus_read(8'h29, 32'h0, "R9 increment reads 0");
        bus_read(8'h20, 32'h2040, "R9 ctl1");

        // R10 ignored writes
        bus_write(8'h23, 32'hFFFF);
        bus_read(8'h23, 32'h0, "R10 ctl4 reads 0");
        bus_write(8'h2D, 32'hFFFF);
        bus_read(8'h2D, 32'h0060, "R10 test write ignored");
        bus_write(8'h30, 32'hFFFF);
        bus_read(8'h30, 32'h0, "R10 unmapped read");
        bus_read(8'h22, 32'hBEEF, "R10 unmapped write left ctl3");

        // R6 soft reset while full with irq active
        bus_write(8'h20, 32'h2240);
        rx_push(8'h66, 1'b0);
        settle();
        check("R6 precondition irq", {31'h0, irq}, 32'h1);
        bus_write(8'h21, 32'h0004);
        settle();
        check("R6 irq cleared", {31'h0, irq}, 32'h0);
        check("R6 rx_ready", {31'h0, rx_ready}, 32'h1);
        bus_read(8'h21, 32'h0005, "R6 ctl2 bit0 forced");
        bus_read(8'h20, 32'h0000, "R6 ctl1");
        bus_read(8'h22, 32'h0700, "R6 ctl3");
        bus_read(8'h24, 32'h0000, "R6 fifo");
        bus_read(8'h2C, 32'h0000, "R6 msec");
        bus_read(8'h2B, 32'h0004, "R6 baud count");
        bus_read(8'h2A, 32'h0000, "R6 baud mod");
        bus_read(8'h25, 32'h6040, "R6 status1");
        bus_read(8'h00, 32'h4000, "R6 rx word");
        send_byte(32'h00A5, "R6 tx still on");
        settle();
        settle();
        check("queues drained", rd_q.size() + tx_q.size(), 0);
        finish_run();
    end
endmodule